// File: doc/BRIEF.md
# Sampled PC Profiling Register Bank

This block is a small register bank on a 32-bit APB-style slave port. It lets an external debugger look at where a running processor is executing without stopping it. The core supplies its live program counter, context ID, VMID, security and exception-level flags, a power-up indication, a double-lock indication and a flag that says sampling is currently not allowed (profiling prohibited or core in debug state).

Reading the low PC sample word returns the live low half of the program counter. The same read copies the upper PC half, the context ID and the virtualization context into shadow registers, so that the debugger can fetch a consistent set with later reads. The sample registers are guarded by an OS lock that comes out of reset locked and is cleared by writing zero. They are also guarded by the core's power and double-lock state. A status register and two identification registers can always be read; they report power and double lock, which sample registers exist, and whether sampled PC values carry an instruction-set offset.

Two state machines control the block. The bus phase tracker has the states PH_IDLE, PH_SETUP and PH_ACCESS. It moves to PH_SETUP on a select without enable, to PH_ACCESS on a select with enable, and back to PH_IDLE when the select drops. A transfer takes effect only in an enable cycle that directly follows a setup cycle. The lock machine has the states LK_LOCKED (the reset state) and LK_OPEN. A write of zero to the lock register moves it to LK_OPEN, and a write of any non-zero value returns it to LK_LOCKED.

Top module: `pcsamp_bank`

## Requirements
- R1: `pready` is always 1 and `pslverr` is always 0. Read data is valid in the enable cycle of every transfer, with no wait states, including back-to-back transfers.
- R2: The OS lock is set after reset. A write of 0x00000000 to offset 0x300 clears it. A write of any non-zero value to 0x300 sets it again.
- R3: While the OS lock is set, or `core_pwr_up` is 0, or `dbl_lock` is 1, reads of offsets 0x0A0, 0x0A4, 0x0A8 and 0x0AC return zero and leave the shadow registers unchanged.
- R4: When access is open and `sample_block` is 0, a read of 0x0A0 returns `pc_live[31:0]`. At the end of that transfer it latches `pc_live[63:32]` into 0x0AC, `ctx_id` into 0x0A4 and the virtualization context into 0x0A8.
- R5: Offsets 0x0A4, 0x0A8 and 0x0AC return the values latched by the last capturing read of 0x0A0. Later changes of the live inputs do not show until the next capturing read.
- R6: When access is open and `sample_block` is 1, a read of 0x0A0 returns 0xFFFFFFFF and leaves the shadow registers unchanged.
- R7: Offset 0x314 can be read at any time. Bit 0 is `core_pwr_up`, bit 6 is `dbl_lock`, and all other bits are zero.
- R8: The virtualization context word has `nonsecure` in bit 31, `at_el2` in bit 30, `at_el3` in bit 29, `wide64` in bit 28 and `vmid` in bits 7:0. All other bits are zero.
- R9: Offset 0xFC8 reads CAP_MODE in bits 3:0 (default 3: PC, context ID and virtualization context all present). With CAP_MODE 2, offset 0xA8 reads zero. Offset 0xFC4 reads PC_OFS_MODE in bits 3:0 (default 0: sampled PCs carry an instruction-set offset).
- R10: Writes to any offset other than 0x300 have no effect. Reads of unmapped offsets return zero with no error response.
- R11: A capturing read of 0x0A0 followed directly by a read of 0x0AC, with no idle cycle between them, returns the newly latched upper PC half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Enable (second phase of a transfer) |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Never signals an error |
| pc_live | input | PC_W | Live program counter |
| ctx_id | input | CTX_W | Live context ID |
| vmid | input | VMID_W | Live virtual machine ID |
| nonsecure | input | 1 | Core is in non-secure state |
| at_el2 | input | 1 | Core is at exception level 2 |
| at_el3 | input | 1 | Core is at exception level 3 |
| wide64 | input | 1 | Core is running in 64-bit state |
| core_pwr_up | input | 1 | Core power domain is up |
| dbl_lock | input | 1 | OS double lock is set |
| sample_block | input | 1 | Sampling prohibited or core in debug state |

## Verification
The assertions assume the bus follows the two-phase protocol. Every enable cycle directly follows a setup cycle with the same address, direction and data. The core-side inputs are assumed to hold steady during the setup and enable cycles of a transfer, because the checks compare read data with those inputs in the same cycle. The bench drives every bus signal and every core input only on the falling clock edge. It changes core inputs only between transfers, and it builds every transfer from a full setup cycle followed by a single enable cycle. This keeps all stimulus inside those assumptions.

// File: rtl/pcsamp_pkg.sv
package pcsamp_pkg;

    localparam int OFS_W = 12;

    localparam logic [OFS_W-1:0] OFS_PC_LO  = 12'h0A0;
    localparam logic [OFS_W-1:0] OFS_CTX    = 12'h0A4;
    localparam logic [OFS_W-1:0] OFS_VCTX   = 12'h0A8;
    localparam logic [OFS_W-1:0] OFS_PC_HI  = 12'h0AC;
    localparam logic [OFS_W-1:0] OFS_OSLOCK = 12'h300;
    localparam logic [OFS_W-1:0] OFS_STATUS = 12'h314;
    localparam logic [OFS_W-1:0] OFS_DEVID1 = 12'hFC4;
    localparam logic [OFS_W-1:0] OFS_DEVID  = 12'hFC8;

    localparam int STAT_PWR_BIT = 0;
    localparam int STAT_DLK_BIT = 6;

    localparam int VC_NS_BIT   = 31;
    localparam int VC_EL2_BIT  = 30;
    localparam int VC_EL3_BIT  = 29;
    localparam int VC_WIDE_BIT = 28;

    localparam logic [31:0] PROHIBITED_WORD = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACCESS
    } apb_phase_e;

    typedef enum logic {
        LK_LOCKED,
        LK_OPEN
    } lock_state_e;

    typedef struct packed {
        logic [31:0] pc_hi;
        logic [31:0] ctx;
        logic [31:0] vctx;
    } sample_t;

endpackage

// File: rtl/pcsamp_apb_fsm.sv
module pcsamp_apb_fsm
    import pcsamp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       psel,
    input  logic       penable,
    output logic       acc_fire,
    output apb_phase_e phase
);

    apb_phase_e state_q;
    apb_phase_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = PH_IDLE;
        unique case (state_q)
            PH_IDLE: begin
                if (psel && !penable) state_d = PH_SETUP;
            end
            PH_SETUP: begin
                if (psel && penable)       state_d = PH_ACCESS;
                else if (psel && !penable) state_d = PH_SETUP;
            end
            PH_ACCESS: begin
                if (psel && !penable) state_d = PH_SETUP;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // Outputs: a transfer fires only in an enable cycle that follows a setup
    always_comb begin
        acc_fire = 1'b0;
        phase    = state_q;
        unique case (state_q)
            PH_SETUP:  acc_fire = psel && penable;
            PH_IDLE,
            PH_ACCESS: acc_fire = 1'b0;
            default:   acc_fire = 1'b0;
        endcase
    end

endmodule

// File: rtl/pcsamp_lock_fsm.sv
module pcsamp_lock_fsm
    import pcsamp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lock_wr,
    input  logic wr_is_zero,
    output logic locked
);

    lock_state_e state_q;
    lock_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LK_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: if (lock_wr && wr_is_zero)  state_d = LK_OPEN;
            LK_OPEN:   if (lock_wr && !wr_is_zero) state_d = LK_LOCKED;
            default:   state_d = LK_LOCKED;
        endcase
    end

    always_comb begin
        unique case (state_q)
            LK_OPEN:   locked = 1'b0;
            LK_LOCKED: locked = 1'b1;
            default:   locked = 1'b1;
        endcase
    end

endmodule

// File: rtl/pcsamp_shadow.sv
module pcsamp_shadow
    import pcsamp_pkg::*;
#(
    parameter bit HAS_VCTX = 1'b1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    capture,
    input  sample_t live,
    output sample_t held
);

    logic [31:0] pc_hi_q;
    logic [31:0] ctx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_hi_q <= '0;
            ctx_q   <= '0;
        end else if (capture) begin
            pc_hi_q <= live.pc_hi;
            ctx_q   <= live.ctx;
        end
    end

    generate
        if (HAS_VCTX) begin : g_vctx
            logic [31:0] vctx_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vctx_q <= '0;
                end else if (capture) begin
                    vctx_q <= live.vctx;
                end
            end
            assign held.vctx = vctx_q;
        end else begin : g_no_vctx
            logic unused_vctx;
            assign unused_vctx = ^live.vctx;
            assign held.vctx   = '0;
        end
    endgenerate

    assign held.pc_hi = pc_hi_q;
    assign held.ctx   = ctx_q;

endmodule

// File: rtl/pcsamp_bank.sv
module pcsamp_bank
    import pcsamp_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int PC_W        = 64,
    parameter int CTX_W       = 32,
    parameter int VMID_W      = 8,
    parameter int CAP_MODE    = 3,
    parameter int PC_OFS_MODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [PC_W-1:0]   pc_live,
    input  logic [CTX_W-1:0]  ctx_id,
    input  logic [VMID_W-1:0] vmid,
    input  logic              nonsecure,
    input  logic              at_el2,
    input  logic              at_el3,
    input  logic              wide64,
    input  logic              core_pwr_up,
    input  logic              dbl_lock,
    input  logic              sample_block
);

    localparam int  DATA_W   = 32;
    localparam int  HI_W     = PC_W - DATA_W;
    localparam bit  HAS_PC   = (CAP_MODE >= 2);
    localparam bit  HAS_VCTX = (CAP_MODE == 3);
    localparam logic [DATA_W-1:0] DEVID_WORD  = DATA_W'(CAP_MODE[3:0]);
    localparam logic [DATA_W-1:0] DEVID1_WORD = DATA_W'(PC_OFS_MODE[3:0]);

    logic       acc_fire;
    apb_phase_e phase;
    logic       rd_fire;
    logic       wr_fire;
    logic       os_locked;
    logic       gate_open;
    logic       capture;
    sample_t    live_s;
    sample_t    held;
    logic [DATA_W-1:0] rdata;

    pcsamp_apb_fsm u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .psel     (psel),
        .penable  (penable),
        .acc_fire (acc_fire),
        .phase    (phase)
    );

    assign rd_fire = acc_fire && !pwrite;
    assign wr_fire = acc_fire && pwrite;

    pcsamp_lock_fsm u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_wr    (wr_fire && (paddr == ADDR_W'(OFS_OSLOCK))),
        .wr_is_zero (pwdata == '0),
        .locked     (os_locked)
    );

    assign gate_open = !os_locked && core_pwr_up && !dbl_lock && HAS_PC;

    // Live context word: flags in the top nibble, VMID zero-extended below
    always_comb begin
        live_s.pc_hi = DATA_W'(pc_live[PC_W-1 -: HI_W]);
        live_s.ctx   = DATA_W'(ctx_id);
        live_s.vctx  = DATA_W'(vmid);
        live_s.vctx[VC_NS_BIT]   = nonsecure;
        live_s.vctx[VC_EL2_BIT]  = at_el2;
        live_s.vctx[VC_EL3_BIT]  = at_el3;
        live_s.vctx[VC_WIDE_BIT] = wide64;
    end

    assign capture = rd_fire && (paddr == ADDR_W'(OFS_PC_LO)) &&
                     gate_open && !sample_block;

    pcsamp_shadow #(
        .HAS_VCTX (HAS_VCTX)
    ) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .live    (live_s),
        .held    (held)
    );

    always_comb begin
        rdata = '0;
        if (rd_fire) begin
            case (paddr)
                ADDR_W'(OFS_PC_LO): begin
                    if (gate_open) rdata = sample_block ? PROHIBITED_WORD : pc_live[DATA_W-1:0];
                end
                ADDR_W'(OFS_PC_HI): if (gate_open) rdata = held.pc_hi;
                ADDR_W'(OFS_CTX):   if (gate_open) rdata = held.ctx;
                ADDR_W'(OFS_VCTX):  if (gate_open) rdata = held.vctx;
                ADDR_W'(OFS_STATUS): begin
                    rdata[STAT_PWR_BIT] = core_pwr_up;
                    rdata[STAT_DLK_BIT] = dbl_lock;
                end
                ADDR_W'(OFS_DEVID):  rdata = DEVID_WORD;
                ADDR_W'(OFS_DEVID1): rdata = DEVID1_WORD;
                default:             rdata = '0;
            endcase
        end
    end

    logic unused_phase;
    assign unused_phase = ^phase;

    assign prdata  = rdata;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

endmodule

// File: rtl/pcsamp_bank_chk.sv
module pcsamp_bank_chk
    import pcsamp_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PC_W   = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_fire,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       pwdata,
    input logic [31:0]       prdata,
    input logic              pready,
    input logic              pslverr,
    input logic [PC_W-1:0]   pc_live,
    input logic              core_pwr_up,
    input logic              dbl_lock,
    input logic              sample_block,
    input logic              os_locked,
    input logic [31:0]       held_hi
);

    logic rd_lo;
    logic rd_sample;
    logic shut;
    assign rd_lo     = acc_fire && !pwrite && (paddr == ADDR_W'(OFS_PC_LO));
    assign rd_sample = acc_fire && !pwrite &&
                       (paddr == ADDR_W'(OFS_PC_LO) || paddr == ADDR_W'(OFS_PC_HI) ||
                        paddr == ADDR_W'(OFS_CTX)   || paddr == ADDR_W'(OFS_VCTX));
    assign shut      = os_locked || !core_pwr_up || dbl_lock;

    AST_BUS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        pready && !pslverr); // R1

    AST_UNLOCK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fire && pwrite && paddr == ADDR_W'(OFS_OSLOCK) && pwdata == '0) |=> !os_locked); // R2

    AST_RELOCK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fire && pwrite && paddr == ADDR_W'(OFS_OSLOCK) && pwdata != '0) |=> os_locked); // R2

    AST_GATED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sample && shut) |-> (prdata == '0)); // R3

    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && shut) |=> $stable(held_hi)); // R3

    AST_CAPTURE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !shut && !sample_block) |=> (held_hi == 32'($past(pc_live[PC_W-1:32])))); // R4

    AST_LIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !shut && !sample_block) |-> (prdata == pc_live[31:0])); // R4

    AST_PROHIB_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && !shut && sample_block) |-> (prdata == 32'hFFFF_FFFF)); // R6

    AST_PROHIB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && sample_block) |=> $stable(held_hi)); // R6

    AST_STATUS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_fire && !pwrite && paddr == ADDR_W'(OFS_STATUS)) |->
        (prdata[0] == core_pwr_up && prdata[6] == dbl_lock &&
         $countones(prdata) == 32'(core_pwr_up) + 32'(dbl_lock))); // R7

endmodule

bind pcsamp_bank pcsamp_bank_chk #(
    .ADDR_W (ADDR_W),
    .PC_W   (PC_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_fire     (acc_fire),
    .pwrite       (pwrite),
    .paddr        (paddr),
    .pwdata       (pwdata),
    .prdata       (prdata),
    .pready       (pready),
    .pslverr      (pslverr),
    .pc_live      (pc_live),
    .core_pwr_up  (core_pwr_up),
    .dbl_lock     (dbl_lock),
    .sample_block (sample_block),
    .os_locked    (os_locked),
    .held_hi      (held.pc_hi)
);

// File: tb/tb_pcsamp_bank.sv
module tb_pcsamp_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic [63:0] pc_live = 64'h0;
    logic [31:0] ctx_id = '0;
    logic [7:0]  vmid = '0;
    logic        nonsecure = 1'b0;
    logic        at_el2 = 1'b0;
    logic        at_el3 = 1'b0;
    logic        wide64 = 1'b0;
    logic        core_pwr_up = 1'b1;
    logic        dbl_lock = 1'b0;
    logic        sample_block = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [31:0] exp_hi;
    logic [31:0] exp_ctx;
    logic [31:0] exp_vctx;

    always #4 clk = ~clk;

    pcsamp_bank dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .pc_live(pc_live), .ctx_id(ctx_id), .vmid(vmid), .nonsecure(nonsecure),
        .at_el2(at_el2), .at_el3(at_el3), .wide64(wide64), .core_pwr_up(core_pwr_up),
        .dbl_lock(dbl_lock), .sample_block(sample_block)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #2;
        d = prdata;
        check("R1 ready", {31'b0, pready}, 32'h1);
        check("R1 slverr", {31'b0, pslverr}, 32'h0);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = v;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    function automatic logic [31:0] vword(input logic n, input logic e2, input logic e3,
                                          input logic w, input logic [7:0] v);
        return {n, e2, e3, w, 20'h0, v};
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        apb_rd(12'h314, d); check("R7 status after reset", d, 32'h0000_0001);
        apb_rd(12'h0A0, d); check("R2 locked after reset, low read zero", d, 32'h0);
        apb_rd(12'h0AC, d); check("R3 high read zero while locked", d, 32'h0);
    endtask

    task automatic t_devid();
        logic [31:0] d;
        apb_rd(12'hFC8, d); check("R9 capability id", d, 32'h3);
        apb_rd(12'hFC4, d); check("R9 offset id", d, 32'h0);
    endtask

    task automatic t_capture();
        logic [31:0] d;
        apb_wr(12'h300, 32'h0);
        pc_live = 64'h1234_5678_9ABC_DEF0; ctx_id = 32'hCAFE_0001;
        nonsecure = 1'b1; at_el2 = 1'b0; at_el3 = 1'b1; wide64 = 1'b1; vmid = 8'h5A;
        apb_rd(12'h0A0, d); check("R4 live low word", d, 32'h9ABC_DEF0);
        exp_hi = 32'h1234_5678; exp_ctx = 32'hCAFE_0001; exp_vctx = vword(1, 0, 1, 1, 8'h5A);
        pc_live = 64'hAAAA_BBBB_CCCC_DDD0; ctx_id = 32'h0BAD_F00D;
        nonsecure = 1'b0; at_el2 = 1'b1; at_el3 = 1'b0; wide64 = 1'b0; vmid = 8'h13;
        apb_rd(12'h0AC, d); check("R5 latched high word", d, exp_hi);
        apb_rd(12'h0A4, d); check("R5 latched context id", d, exp_ctx);
        apb_rd(12'h0A8, d); check("R8 latched vctx layout", d, exp_vctx);
        apb_rd(12'h0A0, d); check("R4 second low read", d, 32'hCCCC_DDD0);
        exp_hi = 32'hAAAA_BBBB; exp_ctx = 32'h0BAD_F00D; exp_vctx = vword(0, 1, 0, 0, 8'h13);
        apb_rd(12'h0A8, d); check("R8 vctx el2 and vmid", d, exp_vctx);
        apb_rd(12'h0AC, d); check("R4 recaptured high word", d, exp_hi);
    endtask

    task automatic t_prohibited();
        logic [31:0] d;
        sample_block = 1'b1; pc_live = 64'h5555_6666_7777_8888;
        apb_rd(12'h0A0, d); check("R6 prohibited reads all ones", d, 32'hFFFF_FFFF);
        sample_block = 1'b0;
        apb_rd(12'h0AC, d); check("R6 shadow kept after prohibited read", d, exp_hi);
    endtask

    task automatic t_gating();
        logic [31:0] d;
        ctx_id = 32'h1357_9BDF;
        dbl_lock = 1'b1;
        apb_rd(12'h314, d); check("R7 status with double lock", d, 32'h0000_0041);
        apb_rd(12'h0A0, d); check("R3 double lock low read zero", d, 32'h0);
        apb_rd(12'h0A4, d); check("R3 double lock ctx read zero", d, 32'h0);
        dbl_lock = 1'b0;
        apb_rd(12'h0A4, d); check("R3 ctx not captured while double locked", d, exp_ctx);
        core_pwr_up = 1'b0;
        apb_rd(12'h314, d); check("R7 status powered down", d, 32'h0);
        apb_rd(12'h0A0, d); check("R3 powered down low read zero", d, 32'h0);
        core_pwr_up = 1'b1;
        apb_rd(12'h0A4, d); check("R3 ctx not captured while powered down", d, exp_ctx);
    endtask

    task automatic t_relock();
        logic [31:0] d;
        apb_wr(12'h300, 32'h0000_0100);
        apb_rd(12'h0A0, d); check("R2 relocked by non-zero write", d, 32'h0);
        apb_rd(12'h314, d); check("R7 status readable while locked", d, 32'h1);
        apb_wr(12'h300, 32'h0);
        apb_rd(12'h0AC, d); check("R3 shadow kept across lock", d, exp_hi);
        apb_rd(12'h0A0, d); check("R2 reopened by zero write", d, 32'h7777_8888);
        exp_hi = 32'h5555_6666; exp_ctx = 32'h1357_9BDF;
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        apb_wr(12'h0AC, 32'hDEAD_BEEF);
        apb_wr(12'h0A4, 32'hDEAD_BEEF);
        apb_wr(12'hFC8, 32'h0);
        apb_wr(12'h314, 32'hFFFF_FFFF);
        apb_rd(12'h0AC, d); check("R10 write to high word ignored", d, exp_hi);
        apb_rd(12'h0A4, d); check("R10 write to ctx ignored", d, exp_ctx);
        apb_rd(12'hFC8, d); check("R10 write to id ignored", d, 32'h3);
        apb_rd(12'h200, d); check("R10 unmapped read zero", d, 32'h0);
        apb_rd(12'h0B0, d); check("R10 unmapped near bank read zero", d, 32'h0);
    endtask

    task automatic t_back_to_back();
        logic [31:0] d0;
        logic [31:0] d1;
        pc_live = 64'h0F0F_1E1E_2D2D_3C3C;
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = 12'h0A0;
        @(negedge clk);
        penable = 1'b1;
        #2 d0 = prdata;
        @(negedge clk);
        penable = 1'b0; paddr = 12'h0AC;
        pc_live = 64'h9999_8888_7777_6666;
        @(negedge clk);
        penable = 1'b1;
        #2 d1 = prdata;
        check("R11 ready during back-to-back", {31'b0, pready}, 32'h1);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        check("R11 first of pair low word", d0, 32'h2D2D_3C3C);
        check("R11 second of pair fresh high word", d1, 32'h0F0F_1E1E);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_devid();
        t_capture();
        t_prohibited();
        t_gating();
        t_relock();
        t_readonly();
        t_back_to_back();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule